// File: doc/BRIEF.md
# Priority Ternary Key Matcher

This block is a fully pipelined search engine. It holds a small table of ternary rules in which every byte is either an exact value or a wildcard. Each clock cycle it can take one 64-bit key with a valid flag. It compares the key against every rule at once, picks the winning rule, and returns that rule's number together with a valid flag. The result always arrives a fixed number of cycles after the key. Rule 0 is the catch-all: its number is returned whenever no other rule matches.

A separate write port fills the table one symbol at a time, while searching continues. A configurable rule width selects how many of the key's leading bytes take part in the comparison. An externally supplied loader status enables the search. While that status is not "ready", every result is suppressed.

Top module: `ptm_matcher`

## Requirements
- R1: A key is accepted on every cycle in which `key_vld` is high, including back-to-back cycles, and nothing ever stalls.
- R2: `res_vld` is exactly the value of (`key_vld` and `ld_status == 1`) from 7 clock cycles earlier, and `res_idx` belongs to that same key.
- R3: `res_idx` is 32 bits wide and holds a rule number from 0 to RULES-1, with all upper bits zero. Both `res_vld` and `res_idx` are 0 after reset.
- R4: Table byte j of a rule is compared with key bits [63-8j -: 8], so byte 0 lines up with the most significant key byte. A 9-bit symbol of 256 (9'h100) matches any key byte. A symbol from 0 to 255 matches only an equal key byte. Symbols above 256 never match.
- R5: When no rule numbered 1 or higher matches, the result is 0, whatever is stored in rule 0.
- R6: When several rules match, the one with the highest number wins.
- R7: Only bytes j with 8*(j+1) <= `cfg_width_bits` are compared. Valid widths are 24, 32, 40, 48, 56 and 64. The remaining low key bytes have no effect on the result.
- R8: A key presented while `ld_status` is not 1 produces `res_vld` low 7 cycles later.
- R9: When `tw_en` is high at a clock edge, `tw_sym` is written into rule `tw_rule`, byte `tw_byte`. A key presented in the same cycle as the write already sees the new symbol. After reset every table symbol is 256, so a key then resolves to rule RULES-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_width_bits | input | 16 | Rule width in bits, sampled with each key |
| ld_status | input | 4 | Loader status; searching is enabled only when this equals 1 |
| tw_en | input | 1 | Table write strobe |
| tw_rule | input | log2(RULES) | Rule number to write |
| tw_byte | input | log2(NB) | Byte position within the rule (0 = most significant) |
| tw_sym | input | 9 | Symbol to store (256 = wildcard) |
| key_vld | input | 1 | Key valid |
| key_dat | input | 8*NB | Search key |
| res_vld | output | 1 | Result valid, 7 cycles after the key |
| res_idx | output | 32 | Winning rule number |

## Verification
Every result is due exactly seven rising edges after its key is sampled. The bench keeps an eight-slot ring of expected values, written at the moment each key is driven and read back seven steps later. Both writes and reads happen on the falling edge, away from the sampling edge. A table write goes through the same stepping routine and updates the reference table before the expectation for that step is computed, which matches the design's timing. The valid flag is compared every cycle, including cycles in which the search is gated off, and the index is compared whenever a result is expected.

// File: rtl/ptm_pkg.sv
package ptm_pkg;
   localparam int SYM_W    = 9;
   localparam int BYTE_W   = 8;
   localparam int RES_W    = 32;
   localparam logic [3:0] ST_READY = 4'd1;
   typedef logic [SYM_W-1:0] sym_t;
   localparam sym_t SYM_ANY = 9'h100;
endpackage

// File: rtl/ptm_rule_store.sv
module ptm_rule_store
   import ptm_pkg::*;
#(
   parameter int RULES = 16,
   parameter int NB    = 8,
   localparam int RIDX_W = $clog2(RULES),
   localparam int BIDX_W = $clog2(NB)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         we,
   input  logic [RIDX_W-1:0]            wr_rule,
   input  logic [BIDX_W-1:0]            wr_byte,
   input  sym_t                         wr_sym,
   output sym_t [RULES-1:0][NB-1:0]     tbl
);
   for (genvar r = 0; r < RULES; r++) begin : g_row
      for (genvar j = 0; j < NB; j++) begin : g_col
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               tbl[r][j] <= SYM_ANY;
            else if (we && (wr_rule == RIDX_W'(r)) && (wr_byte == BIDX_W'(j)))
               tbl[r][j] <= wr_sym;
         end
      end
   end
endmodule

// File: rtl/ptm_byte_cmp.sv
module ptm_byte_cmp
   import ptm_pkg::*;
#(
   parameter int RULES = 16,
   parameter int NB    = 8
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [NB-1:0][BYTE_W-1:0]          key_b,
   input  logic [NB-1:0]                      byte_en,
   input  sym_t [RULES-1:0][NB-1:0]           tbl,
   output logic [RULES-1:0][NB-1:0]           hit_q
);
   for (genvar r = 0; r < RULES; r++) begin : g_rule
      for (genvar j = 0; j < NB; j++) begin : g_byte
         logic eq_w;
         assign eq_w = (tbl[r][j] == SYM_ANY) || (tbl[r][j] == {1'b0, key_b[j]});
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hit_q[r][j] <= 1'b0;
            else        hit_q[r][j] <= !byte_en[j] || eq_w;
         end
      end
   end
endmodule

// File: rtl/ptm_prio_enc.sv
module ptm_prio_enc #(
   parameter int RULES = 16,
   parameter int GROUP = 4,
   localparam int RIDX_W = $clog2(RULES),
   localparam int NGRP   = RULES / GROUP,
   localparam int LW     = $clog2(GROUP)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RULES-1:0]  vec,
   output logic [RIDX_W-1:0] idx_q
);
   logic [NGRP-1:0]          grp_hit_q;
   logic [NGRP-1:0][LW-1:0]  grp_loc_q;

   // stage A: highest set bit inside each group
   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      logic [LW-1:0] loc_w;
      always_comb begin
         loc_w = '0;
         for (int i = 0; i < GROUP; i++)
            if (vec[g*GROUP + i]) loc_w = LW'(i);
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            grp_hit_q[g] <= 1'b0;
            grp_loc_q[g] <= '0;
         end else begin
            grp_hit_q[g] <= |vec[g*GROUP +: GROUP];
            grp_loc_q[g] <= loc_w;
         end
      end
   end

   // stage B: highest group with a hit; default is rule 0
   logic [RIDX_W-1:0] best_w;
   generate
      if (NGRP == 1) begin : g_single
         assign best_w = grp_hit_q[0] ? RIDX_W'(grp_loc_q[0]) : '0;
      end else begin : g_multi
         always_comb begin
            best_w = '0;
            for (int g = 0; g < NGRP; g++)
               if (grp_hit_q[g])
                  best_w = RIDX_W'(g * GROUP) + RIDX_W'(grp_loc_q[g]);
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) idx_q <= '0;
      else        idx_q <= best_w;
   end
endmodule

// File: rtl/ptm_matcher.sv
module ptm_matcher
   import ptm_pkg::*;
#(
   parameter int RULES = 16,
   parameter int NB    = 8,
   parameter int GROUP = 4,
   localparam int RIDX_W = $clog2(RULES),
   localparam int BIDX_W = $clog2(NB),
   localparam int KEY_W  = NB * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [15:0]       cfg_width_bits,
   input  logic [3:0]        ld_status,
   input  logic              tw_en,
   input  logic [RIDX_W-1:0] tw_rule,
   input  logic [BIDX_W-1:0] tw_byte,
   input  logic [8:0]        tw_sym,
   input  logic              key_vld,
   input  logic [KEY_W-1:0]  key_dat,
   output logic              res_vld,
   output logic [31:0]       res_idx
);
   localparam int LAT = 7;

   // elaboration-time parameter checks
   generate
      if (RULES < 2)             begin : g_e0 $error("RULES must be at least 2"); end
      if (GROUP < 2)             begin : g_e1 $error("GROUP must be at least 2"); end
      if (RULES % GROUP != 0)    begin : g_e2 $error("RULES must be a multiple of GROUP"); end
      if ((1 << $clog2(GROUP)) != GROUP) begin : g_e3 $error("GROUP must be a power of two"); end
      if (NB < 3 || NB > 8)      begin : g_e4 $error("NB must be 3..8"); end
      if (RIDX_W > RES_W)        begin : g_e5 $error("RULES too large for result"); end
   endgenerate

   // S1: input register, status gating and width decode
   logic [KEY_W-1:0] key_q;
   logic [NB-1:0]    en_q;
   logic [LAT-1:0]   vld_sr;
   logic [NB-1:0]    en_w;

   for (genvar j = 0; j < NB; j++) begin : g_en
      assign en_w[j] = (cfg_width_bits >= 16'((j + 1) * BYTE_W));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_q  <= '0;
         en_q   <= '0;
         vld_sr <= '0;
      end else begin
         key_q  <= key_dat;
         en_q   <= en_w;
         vld_sr <= {vld_sr[LAT-2:0], key_vld && (ld_status == ST_READY)};
      end
   end

   logic [NB-1:0][BYTE_W-1:0] key_b;
   for (genvar j = 0; j < NB; j++) begin : g_kb
      assign key_b[j] = key_q[KEY_W-1-BYTE_W*j -: BYTE_W];
   end

   // rule table
   sym_t [RULES-1:0][NB-1:0] tbl;
   ptm_rule_store #(.RULES(RULES), .NB(NB)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (tw_en),
      .wr_rule (tw_rule),
      .wr_byte (tw_byte),
      .wr_sym  (tw_sym),
      .tbl     (tbl)
   );

   // S2: byte compare
   logic [RULES-1:0][NB-1:0] hit_q;
   ptm_byte_cmp #(.RULES(RULES), .NB(NB)) u_cmp (
      .clk     (clk),
      .rst_n   (rst_n),
      .key_b   (key_b),
      .byte_en (en_q),
      .tbl     (tbl),
      .hit_q   (hit_q)
   );

   // S3: rule match reduction
   logic [RULES-1:0] match_q;
   for (genvar r = 0; r < RULES; r++) begin : g_red
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) match_q[r] <= 1'b0;
         else        match_q[r] <= &hit_q[r];
      end
   end

   // S4, S5: two-level priority encode
   logic [RIDX_W-1:0] enc_idx;
   ptm_prio_enc #(.RULES(RULES), .GROUP(GROUP)) u_enc (
      .clk   (clk),
      .rst_n (rst_n),
      .vec   (match_q),
      .idx_q (enc_idx)
   );

   // S6, S7: output registers
   logic [RIDX_W-1:0] idx6_q, idx7_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx6_q <= '0;
         idx7_q <= '0;
      end else begin
         idx6_q <= enc_idx;
         idx7_q <= idx6_q;
      end
   end

   assign res_vld = vld_sr[LAT-1];
   assign res_idx = RES_W'(idx7_q);
endmodule

// File: rtl/ptm_chk.sv
module ptm_chk #(
   parameter int RULES = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             key_vld,
   input logic [3:0]       ld_status,
   input logic             res_vld,
   input logic [31:0]      res_idx,
   input logic [RULES-1:0] match_vec
);
   logic [3:0]       cyc;
   logic [RULES-1:0] md1, md2, md3, md4;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc <= '0;
         md1 <= '0; md2 <= '0; md3 <= '0; md4 <= '0;
      end else begin
         if (cyc < 4'd8) cyc <= cyc + 4'd1;
         md1 <= match_vec; md2 <= md1; md3 <= md2; md4 <= md3;
      end
   end

   AST_VLD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 4'd7) |-> (res_vld == $past(key_vld && (ld_status == 4'd1), 7))); // R2

   AST_GATED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      ((cyc >= 4'd7) && $past(ld_status != 4'd1, 7)) |-> !res_vld); // R8

   AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      res_vld |-> (res_idx < 32'(RULES))); // R3

   AST_WINNER_MATCHED: assert property (@(posedge clk) disable iff (!rst_n)
      (res_vld && (cyc >= 4'd8) && (res_idx != 32'd0)) |-> md4[res_idx[$clog2(RULES)-1:0]]); // R5

   AST_NO_HIGHER_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (res_vld && (cyc >= 4'd8)) |-> ((md4 >> (res_idx + 32'd1)) == '0)); // R6
endmodule

bind ptm_matcher ptm_chk #(.RULES(RULES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .key_vld   (key_vld),
   .ld_status (ld_status),
   .res_vld   (res_vld),
   .res_idx   (res_idx),
   .match_vec (match_q)
);

// File: tb/sim_ptm_matcher.sv
module sim_ptm_matcher;
   localparam int RULES = 16;
   localparam int NB    = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cfg_width_bits = 16'd64;
   logic [3:0]  ld_status = 4'd0;
   logic        tw_en = 1'b0;
   logic [3:0]  tw_rule = '0;
   logic [2:0]  tw_byte = '0;
   logic [8:0]  tw_sym = '0;
   logic        key_vld = 1'b0;
   logic [63:0] key_dat = '0;
   logic        res_vld;
   logic [31:0] res_idx;

   always #2 clk = ~clk;

   ptm_matcher #(.RULES(RULES), .NB(NB), .GROUP(4)) u0 (.*);

   int n_chk = 0, n_bad = 0, t = 0;
   logic [8:0]  mdl [RULES][NB];
   bit          ev [8];
   logic [31:0] ei [8];
   string       et [8];
   logic [7:0]  pool [4] = '{8'h0A, 8'hC0, 8'h14, 8'hFF};

   function automatic logic [31:0] exp_idx(input logic [63:0] k, input int w);
      logic [31:0] res = 0;
      for (int r = 0; r < RULES; r++) begin
         bit ok = 1;
         for (int j = 0; j < NB; j++)
            if (8 * (j + 1) <= w)
               if (mdl[r][j] != 9'h100 && mdl[r][j] != {1'b0, k[63-8*j -: 8]}) ok = 0;
         if (ok) res = r;
      end
      return res;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h (t=%0d)", tag, act, exp, t);
      end
   endtask

   // one cycle: check result due now, drive inputs, advance to next falling edge
   task automatic step(input bit v, input logic [63:0] k, input int w,
                       input logic [3:0] st, input string tag);
      if (t >= 7) begin
         int s = (t - 7) % 8;
         check({"R2 valid ", et[s]}, 32'(res_vld), 32'(ev[s]));
         if (ev[s]) check(et[s], res_idx, ei[s]);
      end
      key_vld = v; key_dat = k; cfg_width_bits = 16'(w); ld_status = st;
      if (tw_en) mdl[tw_rule][tw_byte] = tw_sym;
      ev[t % 8] = v && (st == 4'd1);
      ei[t % 8] = exp_idx(k, w);
      et[t % 8] = tag;
      @(posedge clk);
      @(negedge clk);
      tw_en = 1'b0;
      t++;
   endtask

   task automatic wr(input int r, input int j, input logic [8:0] s);
      tw_en = 1'b1; tw_rule = 4'(r); tw_byte = 3'(j); tw_sym = s;
      step(0, 64'd0, 64, 4'd1, "R9 write");
   endtask

   task automatic fill(input logic [8:0] s);
      for (int r = 0; r < RULES; r++)
         for (int j = 0; j < NB; j++) wr(r, j, (r == 0) ? 9'h100 : s);
   endtask

   initial begin
      #(200000 * 4);
      n_bad++;
      $display("FAIL R1 watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      for (int r = 0; r < RULES; r++)
         for (int j = 0; j < NB; j++) mdl[r][j] = 9'h100;
      repeat (3) @(negedge clk);
      check("R3 reset vld", 32'(res_vld), 0);
      check("R3 reset idx", res_idx, 0);
      rst_n = 1'b1;

      // R9: reset table is all wildcard, highest rule wins
      step(1, 64'h0123456789ABCDEF, 64, 4'd1, "R9 reset table");
      repeat (8) step(0, 64'd0, 64, 4'd1, "R2 idle");

      // directed: other rules never match (symbol 257)
      fill(9'h101);
      for (int j = 0; j < NB; j++) wr(5, j, 9'(8'h11 * (j + 1)));
      wr(9, 0, 9'h011);
      for (int j = 1; j < NB; j++) wr(9, j, 9'h100);
      for (int j = 0; j < NB; j++) wr(7, j, (j < 3) ? 9'(8'hAA + 8'h11 * j) : 9'h000);
      step(1, 64'h1122334455667788, 64, 4'd1, "R6 higher rule wins");
      step(1, 64'h1122334455667789, 64, 4'd1, "R4 wildcard byte match");
      step(1, 64'h2222334455667788, 64, 4'd1, "R5 default rule 0");
      step(1, 64'hAABBCCFFFFFFFFFF, 24, 4'd1, "R7 narrow width ignores low bytes");
      step(1, 64'hAABBCCFFFFFFFFFF, 32, 4'd1, "R7 wider width compares byte 3");
      step(1, 64'hAABBCC0000000000, 64, 4'd1, "R4 exact zero bytes");
      step(1, 64'h1122334455667788, 64, 4'd0, "R8 status 0 gated");
      step(1, 64'h1122334455667788, 64, 4'd2, "R8 status 2 gated");
      step(1, 64'h1122334455667788, 64, 4'd1, "R1 back to back");
      repeat (8) step(0, 64'd0, 64, 4'd1, "R2 idle");

      // random table and keys
      for (int r = 1; r < RULES; r++)
         for (int j = 0; j < NB; j++)
            wr(r, j, ($urandom % 3 == 0) ? 9'h100 : {1'b0, pool[$urandom % 4]});
      for (int i = 0; i < 1500; i++) begin
         int rr = $urandom % RULES;
         int w  = 24 + 8 * ($urandom % 6);
         logic [63:0] k;
         logic [3:0] st = ($urandom % 8 == 0) ? 4'($urandom % 6) : 4'd1;
         for (int j = 0; j < NB; j++)
            k[63-8*j -: 8] = (mdl[rr][j] == 9'h100 || $urandom % 10 == 0)
                             ? pool[$urandom % 4] : mdl[rr][j][7:0];
         step($urandom % 5 != 0, k, w, st, "R6 random priority");
      end
      repeat (8) step(0, 64'd0, 64, 4'd1, "R2 drain");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule